// File: doc/BRIEF.md
# System control register bank

This block is a bank of 32-bit control and status registers for the global configuration of a chip. A simple register bus reaches it through a 4 KiB byte-addressed window. The bus carries an address, a write enable, a read enable and write data, and it returns registered read data. Only word-aligned accesses reach a register. The register index is the byte address shifted right by two, and data is little-endian, so bit 0 of a word is bit 0 of the lowest byte.

Each register has one fixed write policy. Some registers are read-only. Some clear the bits written as one, some set the bits written as one, and the rest are plain read/write storage. Most reset values are constants. Three registers take theirs from outside the constant set: the strap register copies the strap input bus, the module-disable register copies the disable-mask input bus, and the memory-configuration register holds a field derived from the DRAM size parameter. A synchronous reset reloads all of them, including the values sampled from the inputs.

Top module: `sys_ctl_regs`

## Requirements
- R1: After reset, byte address 0x000 reads 0x04A92750, 0x008 reads 0x0000FFFF, 0x038 reads 0x00000003, 0x03C reads 0x0000035E and 0x050 reads 0x0000004E. Address 0x060 reads 0x00080000, 0x06C reads 0x80000000, 0x078 reads 0x000000C0 and 0x098 reads 0x5A00F3CF. Address 0x13C reads 0x00000008, both 0x140 and 0x144 read 0x034730E4, and every other implemented register without an input-loaded value reads 0.
- R2: Every reset cycle loads address 0x004 from `strapIn` and address 0x07C from `modDisIn`. A later reset reloads both from the values present on the inputs at that time.
- R3: Address 0x09C resets to 0x00001002 ORed with (DRAM_LOG2 - 27) << 8. DRAM_LOG2 must lie between 27 and 31, and elaboration fails outside that range.
- R4: Read data appears on `rdData` in the cycle after the clock edge that sampled `rdEn`. In any cycle after an edge where `rdEn` was low, `rdData` is 0.
- R5: Writes to addresses 0x000, 0x004 and 0x03C have no effect.
- R6: Addresses 0x06C and 0x0D4 are write-one-to-clear: new = old & ~wrData.
- R7: Addresses 0x070 and 0x07C are write-one-to-set: new = old | wrData.
- R8: All other implemented registers take the full write data on the edge where `wrEn` is high.
- R9: There are 82 registers (0x000 to 0x144). A read at a higher word index returns 0, and a write there changes no register.
- R10: An access with `addr[1:0]` not zero is rejected: the read returns 0 and the write changes no register.
- R11: A read and a write to the same register in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, reloads all reset values |
| addr | input | 12 | Byte address within the 4 KiB window |
| wrEn | input | 1 | Write request, applied on this clock edge |
| rdEn | input | 1 | Read request, data returned one cycle later |
| wrData | input | 32 | Write data |
| strapIn | input | 32 | Strap value loaded into 0x004 at reset |
| modDisIn | input | 32 | Disable mask loaded into 0x07C at reset |
| rdData | output | 32 | Registered read data |

## Verification
The clear-on-one registers are written with a mask that misses the set bit and then with one that hits it. This shows a real AND-NOT from a plain store and from an ignored write. The set-on-one registers take two overlapping masks and then an all-zero write, which shows accumulation rather than replacement. Plain registers are overwritten with a value that clears bits set earlier, which shows a full store from an OR. Writes at an index beyond the bank and at a misaligned address are each followed by a read of the register they could alias. A second reset with different straps shows that the inputs are sampled again and not latched once.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int ADDR_W   = 12;
  localparam int IDX_W    = ADDR_W - 2;
  localparam int DATA_W   = 32;
  localparam int NUM_REGS = 82;

  localparam int IDX_DEVID   = 0;
  localparam int IDX_STRAP   = 1;
  localparam int IDX_INTSTAT = 15;
  localparam int IDX_RSTSTAT = 27;
  localparam int IDX_LOCK    = 28;
  localparam int IDX_MODDIS  = 31;
  localparam int IDX_MEMCFG  = 39;
  localparam int IDX_CPHOST  = 53;

  localparam logic [DATA_W-1:0] MEMCFG_BASE = 32'h0000_1002;
  localparam int MEMCFG_SHIFT = 8;
  localparam int DRAM_MIN_LOG2 = 27;
  localparam int DRAM_MAX_LOG2 = 31;

  typedef enum logic [1:0] {
    POL_RW  = 2'd0,
    POL_RO  = 2'd1,
    POL_W1C = 2'd2,
    POL_W1S = 2'd3
  } policy_e;

  typedef struct packed {
    logic             wr;
    logic             rdOk;
    logic [IDX_W-1:0] idx;
    logic [DATA_W-1:0] data;
  } strobe_t;

  function automatic policy_e polOf(input int idx);
    case (idx)
      IDX_DEVID, IDX_STRAP, IDX_INTSTAT: polOf = POL_RO;
      IDX_RSTSTAT, IDX_CPHOST:           polOf = POL_W1C;
      IDX_LOCK, IDX_MODDIS:              polOf = POL_W1S;
      default:                           polOf = POL_RW;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] baseRst(input int idx);
    case (idx)
      0:  baseRst = 32'h04A9_2750;
      2:  baseRst = 32'h0000_FFFF;
      14: baseRst = 32'h0000_0003;
      15: baseRst = 32'h0000_035E;
      20: baseRst = 32'h0000_004E;
      24: baseRst = 32'h0008_0000;
      27: baseRst = 32'h8000_0000;
      30: baseRst = 32'h0000_00C0;
      38: baseRst = 32'h5A00_F3CF;
      79: baseRst = 32'h0000_0008;
      80: baseRst = 32'h0347_30E4;
      81: baseRst = 32'h0347_30E4;
      default: baseRst = '0;
    endcase
  endfunction

endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter int REG_COUNT = NUM_REGS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output strobe_t           strb
);

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             inRange;
  logic             roHit;

  assign idx     = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign inRange = (int'(idx) < REG_COUNT);

  // Writes are gated here for read-only targets.
  always_comb begin
    roHit = 1'b0;
    for (int k = 0; k < REG_COUNT; k++) begin
      if (idx == IDX_W'(k) && polOf(k) == POL_RO) roHit = 1'b1;
    end
  end

  always_comb begin
    strb.wr   = wrEn && aligned && inRange && !roHit && !rst;
    strb.rdOk = rdEn && aligned && inRange && !rst;
    strb.idx  = idx;
    strb.data = wrData;
  end

endmodule

// File: rtl/sysctl_datapath.sv
module sysctl_datapath
  import sysctl_pkg::*;
#(
  parameter int REG_COUNT = NUM_REGS,
  parameter int DRAM_LOG2 = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] strapIn,
  input  logic [DATA_W-1:0] modDisIn,
  output logic [DATA_W-1:0] rdData
);

  localparam logic [DATA_W-1:0] MEMCFG_RST =
    MEMCFG_BASE | (DATA_W'(DRAM_LOG2 - DRAM_MIN_LOG2) << MEMCFG_SHIFT);

  logic [DATA_W-1:0] regs [REG_COUNT];
  logic [DATA_W-1:0] rdSel;

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    localparam policy_e POL = polOf(i);
    logic [DATA_W-1:0] rstVal;
    logic              hit;

    if (i == IDX_STRAP) begin : g_strap
      assign rstVal = strapIn;
    end else if (i == IDX_MODDIS) begin : g_moddis
      assign rstVal = modDisIn;
    end else if (i == IDX_MEMCFG) begin : g_memcfg
      assign rstVal = MEMCFG_RST;
    end else begin : g_const
      assign rstVal = baseRst(i);
    end

    assign hit = strb.wr && (strb.idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        regs[i] <= rstVal;
      end else if (hit) begin
        case (POL)
          POL_W1C: regs[i] <= regs[i] & ~strb.data;
          POL_W1S: regs[i] <= regs[i] | strb.data;
          POL_RO:  regs[i] <= regs[i];
          default: regs[i] <= strb.data;
        endcase
      end
    end
  end

  always_comb begin
    rdSel = '0;
    for (int k = 0; k < REG_COUNT; k++) begin
      if (strb.idx == IDX_W'(k)) rdSel = regs[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            rdData <= '0;
    else if (strb.rdOk) rdData <= rdSel;
    else                rdData <= '0;
  end

endmodule

// File: rtl/sys_ctl_regs.sv
module sys_ctl_regs
  import sysctl_pkg::*;
#(
  parameter int REG_COUNT = NUM_REGS,
  parameter int DRAM_LOG2 = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] strapIn,
  input  logic [DATA_W-1:0] modDisIn,
  output logic [DATA_W-1:0] rdData
);

  // R3: the memory size exponent is checked at elaboration
  if (DRAM_LOG2 < DRAM_MIN_LOG2 || DRAM_LOG2 > DRAM_MAX_LOG2) begin : g_bad_dram
    $error("DRAM_LOG2 out of the supported range");
  end

  strobe_t strb;

  sysctl_ctrl #(.REG_COUNT(REG_COUNT)) i_ctrl (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .strb(strb)
  );

  sysctl_datapath #(.REG_COUNT(REG_COUNT), .DRAM_LOG2(DRAM_LOG2)) i_dp (
    .clk(clk), .rst(rst), .strb(strb), .strapIn(strapIn),
    .modDisIn(modDisIn), .rdData(rdData)
  );

endmodule

// File: rtl/sys_ctl_regs_chk.sv
module sys_ctl_regs_chk
  import sysctl_pkg::*;
#(
  parameter int REG_COUNT = NUM_REGS
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              rdEn,
  input logic [DATA_W-1:0] rdData
);

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(rdEn) |-> rdData == '0); // R4

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(rdEn) && (int'($past(addr[ADDR_W-1:2])) >= REG_COUNT)
    |-> rdData == '0); // R9

  AST_MISALIGN_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(rdEn) && ($past(addr[1:0]) != 2'b00) |-> rdData == '0); // R10

  AST_DEVID_FIXED: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(rdEn) && ($past(addr) == 12'h000) |-> rdData == 32'h04A9_2750); // R5

  AST_INTSTAT_FIXED: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(rdEn) && ($past(addr) == 12'h03C) |-> rdData == 32'h0000_035E); // R5

endmodule

bind sys_ctl_regs sys_ctl_regs_chk #(.REG_COUNT(REG_COUNT)) i_chk (
  .clk(clk), .rst(rst), .addr(addr), .rdEn(rdEn), .rdData(rdData)
);

// File: tb/test_sys_ctl_regs.sv
module test_sys_ctl_regs;

  localparam int DRAM_L = 30;
  localparam logic [31:0] MEMCFG_EXP = 32'h0000_1002 | (32'(DRAM_L - 27) << 8);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] addr = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] strapIn = 32'hA5A5_0001;
  logic [31:0] modDisIn = 32'h0000_00F0;
  logic [31:0] rdData;

  int checks = 0;
  int fails = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  sys_ctl_regs #(.DRAM_LOG2(DRAM_L)) i_sys_ctl_regs (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .strapIn(strapIn), .modDisIn(modDisIn), .rdData(rdData)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doWr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrEn = 1'b1; rdEn = 1'b0; wrData = d;
  endtask

  task automatic doRd(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    addr = a; wrEn = 1'b0; rdEn = 1'b1;
    expQ.push_back(e); tagQ.push_back(tag);
  endtask

  task automatic doRdWr(input logic [11:0] a, input logic [31:0] d,
                        input logic [31:0] e, input string tag);
    @(negedge clk);
    addr = a; wrEn = 1'b1; rdEn = 1'b1; wrData = d;
    expQ.push_back(e); tagQ.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
  endtask

  task automatic doReset(input int n);
    @(negedge clk);
    rst = 1'b1; wrEn = 1'b0; rdEn = 1'b0;
    repeat (n) @(negedge clk);
    rst = 1'b0;
  endtask

  // Monitor: a read sampled at an edge is compared at the following falling edge.
  initial begin
    forever begin
      @(posedge clk);
      if (rdEn && !rst) begin
        @(negedge clk);
        if (expQ.size() == 0) begin
          check("R4 unexpected read", rdData, 32'hx);
        end else begin
          check(tagQ.pop_front(), rdData, expQ.pop_front());
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    doReset(4);
    check("R4 reset rdData", rdData, 32'h0);
    // R1 constant reset values
    doRd(12'h000, 32'h04A9_2750, "R1 devid");
    doRd(12'h008, 32'h0000_FFFF, "R1 pull");
    doRd(12'h00C, 32'h0, "R1 zero reg");
    doRd(12'h038, 32'h0000_0003, "R1 0x038");
    doRd(12'h03C, 32'h0000_035E, "R1 intstat");
    doRd(12'h050, 32'h0000_004E, "R1 0x050");
    doRd(12'h060, 32'h0008_0000, "R1 0x060");
    doRd(12'h06C, 32'h8000_0000, "R1 rststat");
    doRd(12'h078, 32'h0000_00C0, "R1 0x078");
    doRd(12'h098, 32'h5A00_F3CF, "R1 0x098");
    doRd(12'h13C, 32'h0000_0008, "R1 0x13C");
    doRd(12'h140, 32'h0347_30E4, "R1 0x140");
    doRd(12'h144, 32'h0347_30E4, "R1 0x144");
    // R2 input-loaded values, R3 memory field
    doRd(12'h004, 32'hA5A5_0001, "R2 strap");
    doRd(12'h07C, 32'h0000_00F0, "R2 moddis");
    doRd(12'h09C, MEMCFG_EXP, "R3 memcfg");
    // R5 read-only
    doWr(12'h000, 32'hFFFF_FFFF);
    doRd(12'h000, 32'h04A9_2750, "R5 devid");
    doWr(12'h004, 32'h0);
    doRd(12'h004, 32'hA5A5_0001, "R5 strap");
    doWr(12'h03C, 32'h0);
    doRd(12'h03C, 32'h0000_035E, "R5 intstat");
    // R6 write-one-to-clear
    doWr(12'h06C, 32'h0000_0001);
    doRd(12'h06C, 32'h8000_0000, "R6 miss mask");
    doWr(12'h06C, 32'h8000_0000);
    doRd(12'h06C, 32'h0, "R6 hit mask");
    doWr(12'h0D4, 32'hFFFF_FFFF);
    doRd(12'h0D4, 32'h0, "R6 cphost");
    // R7 write-one-to-set
    doWr(12'h070, 32'h0000_000F);
    doRd(12'h070, 32'h0000_000F, "R7 lock first");
    doWr(12'h070, 32'h0000_0030);
    doRd(12'h070, 32'h0000_003F, "R7 lock accum");
    doWr(12'h070, 32'h0);
    doRd(12'h070, 32'h0000_003F, "R7 lock zero write");
    doWr(12'h07C, 32'h0000_0001);
    doRd(12'h07C, 32'h0000_00F1, "R7 moddis");
    // R8 plain
    doWr(12'h008, 32'hDEAD_BEEF);
    doRd(12'h008, 32'hDEAD_BEEF, "R8 store");
    doWr(12'h008, 32'h1234_5678);
    doRd(12'h008, 32'h1234_5678, "R8 overwrite");
    doWr(12'h09C, 32'h0);
    doRd(12'h09C, 32'h0, "R8 memcfg writable");
    // R9 beyond the bank
    doWr(12'h148, 32'hFFFF_FFFF);
    doRd(12'h148, 32'h0, "R9 read index 82");
    doRd(12'hFFC, 32'h0, "R9 read top");
    doRd(12'h008, 32'h1234_5678, "R9 no alias");
    doRd(12'h144, 32'h0347_30E4, "R9 last reg intact");
    // R10 misaligned
    doWr(12'h00A, 32'h0);
    doRd(12'h008, 32'h1234_5678, "R10 write dropped");
    doRd(12'h009, 32'h0, "R10 read zero");
    // R11 simultaneous read and write
    doRdWr(12'h13C, 32'hA0A0_A0A0, 32'h0000_0008, "R11 old value");
    doRd(12'h13C, 32'hA0A0_A0A0, "R11 new value");
    // R4 no read -> zero
    idle();
    idle();
    check("R4 idle rdData", rdData, 32'h0);
    // R2 second reset with new inputs
    strapIn = 32'h1234_5678;
    modDisIn = 32'h0000_0F00;
    doReset(2);
    doRd(12'h004, 32'h1234_5678, "R2 strap reload");
    doRd(12'h07C, 32'h0000_0F00, "R2 moddis reload");
    doRd(12'h008, 32'h0000_FFFF, "R1 reload pull");
    doRd(12'h070, 32'h0, "R1 reload lock");
    doRd(12'h09C, MEMCFG_EXP, "R3 reload memcfg");
    idle();
    wait (expQ.size() == 0);
    idle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule